// File: doc/BRIEF.md
# Reloading Interval Timer

This block is a programmable up-counting interval timer. A count register advances by one on every cycle in which the tick-enable input is high and the run flag is set. The tick source is normally a 1 MHz strobe generated elsewhere. When the count steps past all ones it wraps. On a wrap it loads the next-interval register again and keeps counting. It also raises a done flag. If done was still set from the previous wrap, it raises an error flag instead. An interrupt request follows the interrupt-enable bit.

Software controls the block through three registers on a simple write-strobe interface, and reads them back through a combinational read mux.
- The control register holds the flags and two command bits that act at once: transfer and single-step.
- Transfer copies the next interval into the count.
- Single-step advances a stopped counter by one.

The done and error flags clear when a one is written to their bit.

Top module: `ivl_timer`

## Requirements
- R1: After reset the control, count and next-interval registers read zero and `irq` is low.
- R2: Select 0 reads the control word with error at bit 31, done at bit 7, interrupt enable at bit 6 and run at bit 0. Every other bit reads zero, including the write-only command bits 5 (single-step) and 4 (transfer).
- R3: While run is set, each cycle with `tick_en` high adds one to the count (select 1). With run clear, ticks leave the count unchanged.
- R4: When a tick takes the count from all ones to zero with run set, the count instead loads the next-interval value (select 2) and counting continues.
- R5: On every wrap, done is set if it was clear. If done was already set, error is set.
- R6: Writing a one to bit 31 or bit 7 of the control register clears error or done. Writing a zero there leaves the flag unchanged. Bits 6 and 0 are loaded from the written data.
- R7: On a wrap, `irq` becomes the value of interrupt enable.
- R8: After any control write, `irq` is low unless done and interrupt enable are both set.
- R9: A control write with bit 4 set copies the next-interval register into the count.
- R10: A control write with bit 5 set and bit 0 clear adds one to the count. This adds to the transferred value when bit 4 is also set. If the step wraps to zero, the count loads the next interval and the wrap sets the flags as in R5 and R7.
- R11: Bit 5 has no effect when the same write sets bit 0.
- R12: A tick in the same cycle as a control write is ignored.
- R13: The count register cannot be written: writes to select 1 are dropped. Select 2 is read/write. Select 3 reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | Count-enable strobe |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Write register select (0 control, 1 count, 2 next) |
| wr_data | input | DATA_W | Write data |
| rd_sel | input | 2 | Read register select |
| rd_data | output | DATA_W | Read data, combinational from `rd_sel` |
| irq | output | 1 | Interrupt request |

## Verification
On every cycle, the embedded properties check several rules:
- an active request implies done and enable are both set;
- a wrap loads the count from the next interval that was in place before the edge;
- a stopped counter or a plain control write leaves the count untouched;
- a wrap over a pending done raises error.

The flag encodings seen through the read mux need the bench's directed scenarios, driven against a behavioural model. These include a single-step that wraps, combined transfer and step, a step masked by run, and the count-write drop. The same applies to the interplay of write-one-to-clear with a wrap.

// File: rtl/ivl_timer_pkg.sv
package ivl_timer_pkg;

  typedef enum logic [1:0] {
    SEL_CTRL  = 2'd0,
    SEL_COUNT = 2'd1,
    SEL_NEXT  = 2'd2,
    SEL_NONE  = 2'd3
  } reg_sel_e;

  localparam int unsigned BIT_ERR  = 31;
  localparam int unsigned BIT_DONE = 7;
  localparam int unsigned BIT_IE   = 6;
  localparam int unsigned BIT_STEP = 5;
  localparam int unsigned BIT_XFER = 4;
  localparam int unsigned BIT_RUN  = 0;

  typedef struct packed {
    logic wr;
    logic clr_err;
    logic clr_done;
    logic ie;
    logic run;
    logic xfer;
    logic step;
  } ctl_cmd_t;

endpackage

// File: rtl/ivl_timer_decode.sv
module ivl_timer_decode
  import ivl_timer_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic              wr_en,
  input  logic [1:0]        wr_sel,
  input  logic [DATA_W-1:0] wr_data,
  output ctl_cmd_t          cmd,
  output logic              nxt_wr
);

  always_comb begin
    cmd.wr       = wr_en && (wr_sel == SEL_CTRL);
    cmd.clr_err  = wr_data[BIT_ERR];
    cmd.clr_done = wr_data[BIT_DONE];
    cmd.ie       = wr_data[BIT_IE];
    cmd.run      = wr_data[BIT_RUN];
    cmd.xfer     = wr_data[BIT_XFER];
    cmd.step     = wr_data[BIT_STEP];
    nxt_wr       = wr_en && (wr_sel == SEL_NEXT);
  end

endmodule

// File: rtl/ivl_timer_counter.sv
module ivl_timer_counter
  import ivl_timer_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  ctl_cmd_t          cmd,
  input  logic              nxt_wr,
  input  logic [DATA_W-1:0] nxt_data,
  input  logic              tick_en,
  input  logic              run_q,
  output logic [DATA_W-1:0] cnt_q,
  output logic [DATA_W-1:0] nxt_q,
  output logic              wrap_evt
);

  function automatic logic [DATA_W:0] bump(input logic [DATA_W-1:0] v);
    return {1'b0, v} + {{DATA_W{1'b0}}, 1'b1};
  endfunction

  logic [DATA_W-1:0] cnt_d;
  logic [DATA_W-1:0] base;
  logic [DATA_W:0]   sum;
  logic              step_go;
  logic              tick_go;

  assign step_go = cmd.wr && cmd.step && !cmd.run;
  assign tick_go = !cmd.wr && tick_en && run_q;

  always_comb begin
    base     = cmd.xfer ? nxt_q : cnt_q;
    sum      = '0;
    wrap_evt = 1'b0;
    cnt_d    = cnt_q;
    if (cmd.wr) begin
      cnt_d = base;
      if (step_go) begin
        sum      = bump(base);
        wrap_evt = sum[DATA_W];
        cnt_d    = sum[DATA_W] ? nxt_q : sum[DATA_W-1:0];
      end
    end else if (tick_go) begin
      sum      = bump(cnt_q);
      wrap_evt = sum[DATA_W];
      cnt_d    = sum[DATA_W] ? nxt_q : sum[DATA_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
      nxt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
      if (nxt_wr) nxt_q <= nxt_data;
    end
  end

  // R3: a stopped counter without a control write holds its value
  a_r3_hold_when_stopped: assert property (@(posedge clk) disable iff (!rst_n)
    (!cmd.wr && !run_q) |=> $stable(cnt_q));

  // R4: any wrap loads the pre-edge next interval
  a_r4_wrap_reloads: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_evt |=> (cnt_q == $past(nxt_q)));

  // R12: a control write with neither transfer nor an active step keeps the count
  a_r12_tick_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd.wr && !cmd.xfer && !(cmd.step && !cmd.run)) |=> $stable(cnt_q));

  // R9: a transfer without step copies the next interval
  a_r9_transfer: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd.wr && cmd.xfer && !cmd.step) |=> (cnt_q == $past(nxt_q)));

endmodule

// File: rtl/ivl_timer_flags.sv
module ivl_timer_flags
  import ivl_timer_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  ctl_cmd_t cmd,
  input  logic     wrap_evt,
  output logic     err_q,
  output logic     done_q,
  output logic     ie_q,
  output logic     run_q,
  output logic     irq_q
);

  logic err_n, done_n, ie_n, run_n, irq_n;

  always_comb begin
    err_n  = err_q  && !(cmd.wr && cmd.clr_err);
    done_n = done_q && !(cmd.wr && cmd.clr_done);
    ie_n   = cmd.wr ? cmd.ie  : ie_q;
    run_n  = cmd.wr ? cmd.run : run_q;
    irq_n  = irq_q;
    if (wrap_evt) begin
      if (done_n) err_n  = 1'b1;
      else        done_n = 1'b1;
      irq_n = ie_n;
    end
    if (cmd.wr && !(done_n && ie_n)) irq_n = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      err_q  <= 1'b0;
      done_q <= 1'b0;
      ie_q   <= 1'b0;
      run_q  <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      err_q  <= err_n;
      done_q <= done_n;
      ie_q   <= ie_n;
      run_q  <= run_n;
      irq_q  <= irq_n;
    end
  end

  // R8: a pending request always has done and enable behind it
  a_r8_irq_backed: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q |-> (done_q && ie_q));

  // R5: a wrap over an uncleared done raises error
  a_r5_second_wrap_err: assert property (@(posedge clk) disable iff (!rst_n)
    (wrap_evt && done_q && !(cmd.wr && cmd.clr_done)) |=> err_q);

  // R7: after a wrap the request mirrors the enable
  a_r7_irq_tracks_ie: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_evt |=> (irq_q == ie_q));

  // R6: write-one clears error when no wrap competes
  a_r6_w1c_err: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd.wr && cmd.clr_err && !wrap_evt) |=> !err_q);

endmodule

// File: rtl/ivl_timer.sv
module ivl_timer
  import ivl_timer_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en,
  input  logic              wr_en,
  input  logic [1:0]        wr_sel,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [1:0]        rd_sel,
  output logic [DATA_W-1:0] rd_data,
  output logic              irq
);

  function automatic logic [DATA_W-1:0] ctrl_word(input logic e, input logic d,
                                                  input logic i, input logic r);
    logic [DATA_W-1:0] w;
    w = '0;
    w[BIT_ERR]  = e;
    w[BIT_DONE] = d;
    w[BIT_IE]   = i;
    w[BIT_RUN]  = r;
    return w;
  endfunction

  ctl_cmd_t          cmd;
  logic              nxt_wr;
  logic [DATA_W-1:0] cnt_q, nxt_q;
  logic              wrap_evt;
  logic              err_q, done_q, ie_q, run_q, irq_q;

  ivl_timer_decode #(.DATA_W(DATA_W)) u_decode (
    .wr_en   (wr_en),
    .wr_sel  (wr_sel),
    .wr_data (wr_data),
    .cmd     (cmd),
    .nxt_wr  (nxt_wr)
  );

  ivl_timer_counter #(.DATA_W(DATA_W)) u_counter (
    .clk      (clk),
    .rst_n    (rst_n),
    .cmd      (cmd),
    .nxt_wr   (nxt_wr),
    .nxt_data (wr_data),
    .tick_en  (tick_en),
    .run_q    (run_q),
    .cnt_q    (cnt_q),
    .nxt_q    (nxt_q),
    .wrap_evt (wrap_evt)
  );

  ivl_timer_flags u_flags (
    .clk      (clk),
    .rst_n    (rst_n),
    .cmd      (cmd),
    .wrap_evt (wrap_evt),
    .err_q    (err_q),
    .done_q   (done_q),
    .ie_q     (ie_q),
    .run_q    (run_q),
    .irq_q    (irq_q)
  );

  always_comb begin
    case (reg_sel_e'(rd_sel))
      SEL_CTRL:  rd_data = ctrl_word(err_q, done_q, ie_q, run_q);
      SEL_COUNT: rd_data = cnt_q;
      SEL_NEXT:  rd_data = nxt_q;
      default:   rd_data = '0;
    endcase
  end

  assign irq = irq_q;

  // R13: a write aimed at the count register alone never moves a stopped count
  a_r13_count_readonly: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel == SEL_COUNT && !run_q) |=> $stable(cnt_q));

endmodule

// File: tb/ivl_timer_tb_top.sv
`timescale 1ns/100ps
module ivl_timer_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_en = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_sel = 2'd0;
  logic [31:0] wr_data = '0;
  logic [1:0]  rd_sel = 2'd0;
  logic [31:0] rd_data;
  logic        irq;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 0;

  // behavioural reference state
  logic [31:0] m_cnt = '0, m_nxt = '0;
  bit m_err = 0, m_done = 0, m_ie = 0, m_run = 0, m_irq = 0;

  always #2 clk = ~clk;

  ivl_timer #(.DATA_W(32)) dut_i (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .wr_en(wr_en),
    .wr_sel(wr_sel), .wr_data(wr_data), .rd_sel(rd_sel),
    .rd_data(rd_data), .irq(irq)
  );

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, got, exp);
    end
  endtask

  task automatic rd(input logic [1:0] s, output logic [31:0] v);
    rd_sel = s;
    #0.2;
    v = rd_data;
  endtask

  task automatic expect_reg(input string tag, input logic [1:0] s, input logic [31:0] exp);
    logic [31:0] v;
    rd(s, v);
    check(tag, v, exp);
  endtask

  function automatic logic [31:0] m_ctrl();
    return {m_err, 23'd0, m_done, m_ie, 5'd0, m_run};
  endfunction

  function automatic void m_wrap();
    if (m_done) m_err = 1; else m_done = 1;
    m_irq = m_ie;
  endfunction

  function automatic void model(input bit we, input logic [1:0] ws,
                                input logic [31:0] wd, input bit tk);
    if (we && ws == 2'd0) begin
      if (wd[31]) m_err = 0;
      if (wd[7])  m_done = 0;
      m_ie  = wd[6];
      m_run = wd[0];
      if (wd[4]) m_cnt = m_nxt;
      if (wd[5] && !wd[0]) begin
        m_cnt = m_cnt + 1;
        if (m_cnt == 0) begin m_cnt = m_nxt; m_wrap(); end
      end
      if (!(m_done && m_ie)) m_irq = 0;
    end else begin
      if (tk && m_run) begin
        if (m_cnt == 32'hFFFF_FFFF) begin m_cnt = m_nxt; m_wrap(); end
        else m_cnt = m_cnt + 1;
      end
      if (we && ws == 2'd2) m_nxt = wd;
    end
  endfunction

  task automatic compare_all();
    expect_reg("R2 R5 R6 model ctrl", 2'd0, m_ctrl());
    expect_reg("R3 R4 model count", 2'd1, m_cnt);
    expect_reg("R13 model next", 2'd2, m_nxt);
    check("R7 R8 model irq", {31'd0, irq}, {31'd0, m_irq});
  endtask

  task automatic cyc(input bit we, input logic [1:0] ws, input logic [31:0] wd, input bit tk);
    wr_en = we; wr_sel = ws; wr_data = wd; tick_en = tk;
    model(we, ws, wd, tk);
    @(posedge clk);
    @(negedge clk);
    wr_en = 0; tick_en = 0;
    compare_all();
  endtask

  task automatic ctl(input logic [31:0] d, input bit tk = 0); cyc(1, 2'd0, d, tk); endtask
  task automatic nxt(input logic [31:0] d); cyc(1, 2'd2, d, 0); endtask
  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) cyc(0, 2'd0, '0, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    expect_reg("R1 ctrl", 2'd0, 32'h0);
    expect_reg("R1 count", 2'd1, 32'h0);
    expect_reg("R1 next", 2'd2, 32'h0);
    check("R1 irq", {31'd0, irq}, 32'd0);

    nxt(32'hFFFF_FFFD);
    ctl(32'h10);
    expect_reg("R9 transfer", 2'd1, 32'hFFFF_FFFD);
    expect_reg("R2 command bits read zero", 2'd0, 32'h0);
    cyc(1, 2'd1, 32'h1234, 1);
    expect_reg("R13 count not writable", 2'd1, 32'hFFFF_FFFD);
    expect_reg("R13 select 3 reads zero", 2'd3, 32'h0);

    ctl(32'h41);
    expect_reg("R2 run ie layout", 2'd0, 32'h41);
    ticks(2);
    expect_reg("R3 counts ticks", 2'd1, 32'hFFFF_FFFF);
    cyc(0, 2'd0, '0, 0);
    expect_reg("R3 no tick no change", 2'd1, 32'hFFFF_FFFF);
    ticks(1);
    expect_reg("R4 reload on wrap", 2'd1, 32'hFFFF_FFFD);
    expect_reg("R5 done on wrap", 2'd0, 32'h0000_00C1);
    check("R7 irq on wrap", {31'd0, irq}, 32'd1);
    ticks(3);
    expect_reg("R5 error on second wrap", 2'd0, 32'h8000_00C1);

    ctl(32'h41);
    check("R8 irq kept with done and ie", {31'd0, irq}, 32'd1);
    expect_reg("R6 zero bits keep flags", 2'd0, 32'h8000_00C1);
    ctl(32'h8000_0001, 1);
    expect_reg("R6 clear error", 2'd0, 32'h0000_0081);
    check("R8 irq cleared when ie off", {31'd0, irq}, 32'd0);
    expect_reg("R12 tick ignored on write", 2'd1, 32'hFFFF_FFFD);
    ctl(32'h81);
    expect_reg("R6 clear done", 2'd0, 32'h1);
    ticks(3);
    check("R7 no irq with ie clear", {31'd0, irq}, 32'd0);
    expect_reg("R5 done without ie", 2'd0, 32'h81);

    ctl(32'h80);
    ticks(2);
    expect_reg("R3 stopped count holds", 2'd1, 32'hFFFF_FFFD);

    nxt(32'hFFFF_FFFF);
    ctl(32'h10);
    nxt(32'h5);
    ctl(32'h60);
    expect_reg("R10 step wrap reloads", 2'd1, 32'h5);
    expect_reg("R10 step wrap sets done", 2'd0, 32'hC0);
    check("R10 step wrap irq", {31'd0, irq}, 32'd1);
    ctl(32'h20);
    expect_reg("R10 single step", 2'd1, 32'h6);
    check("R8 irq cleared ie off", {31'd0, irq}, 32'd0);
    ctl(32'h21);
    expect_reg("R11 step ignored with run", 2'd1, 32'h6);
    ticks(1);
    expect_reg("R3 count after run", 2'd1, 32'h7);
    ctl(32'h30, 1);
    expect_reg("R9 R10 transfer then step", 2'd1, 32'h6);
    expect_reg("R2 run cleared", 2'd0, 32'h80);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
    end
  end

endmodule